// File: doc/BRIEF.md
# Prescaled Auto-Reload Timer Base

This block is a 16-bit up-counting time base. A prescaler divides the input clock by a programmable ratio. The slowed count then steps a main counter from zero up to a programmable limit. At the limit the counter wraps to zero and raises a one-cycle update pulse.

The prescaler ratio and the limit are written through a small register write port into shadow copies. The prescaler ratio always waits for the next update event before it takes effect. The limit can either take effect at once or wait for the update event, as a mode input selects. A software update input forces an update at any time: it loads both shadows and restarts both counters.

A limit of zero stops the counter entirely. The outputs are the counter value, the update pulse and a count tick that marks each cycle in which the counter advances.

Top module: `tbase_core`

## Requirements
- R1: With active prescaler value P and counting allowed, `cnt_tick` is high for one cycle in every P+1 cycles. `cnt_out` advances on the clock edge that ends each tick cycle.
- R2: A write with `wr_sel`=0 stores `wr_data` as the pending prescaler value. The division ratio is unchanged until the next update event, after which it is P+1.
- R3: With active limit A, the counter counts 0, 1, ..., A. On the tick taken while it equals A, it returns to 0.
- R4: While the active limit is zero, `cnt_out` holds and `cnt_tick` stays low, even with `run_en` high.
- R5: After reset, the pending and active prescaler and limit values, the prescaler counter and `cnt_out` are all zero.
- R6: `update_pulse` is high for exactly the cycle of the tick at the limit, or of a software update. It is low otherwise.
- R7: A write with `wr_sel`=1 stores the pending limit. With `rld_defer`=0 the active limit takes the written value on the same edge. With `rld_defer`=1 it changes only at the next update event.
- R8: A cycle with `sw_update` high raises `update_pulse`, clears `cnt_out` and the prescaler counter, and loads both pending values into the active registers.
- R9: After any update event, the first following tick comes after exactly P+1 counting cycles, where P is the newly active prescaler value.
- R10: While `run_en` is low, `cnt_out` and the prescaler position hold and `cnt_tick` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Allows counting |
| rld_defer | input | 1 | 1: limit writes wait for an update event; 0: they take effect at once |
| sw_update | input | 1 | Forces an update event in this cycle |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 prescaler, 1 limit |
| wr_data | input | 16 | Write value |
| cnt_out | output | 16 | Counter value |
| update_pulse | output | 1 | Update event, one cycle wide |
| cnt_tick | output | 1 | High in each cycle in which the counter advances |

## Verification
The bench keeps the default 16-bit widths for both the prescaler and the counter. It restricts the programmed values to prescaler settings 0 to 3 and limits 1 to 4. This keeps each full period down to a few dozen cycles, so every combination of ratio and limit can be swept over two complete periods, and every count, tick and update cycle is compared against arithmetic on the number of cycles since the last update. The same small settings also bring the timing of mid-period writes, forced updates, pauses and the zero-limit freeze within easy reach.

// File: rtl/tbase_pkg.sv
package tbase_pkg;
  localparam int TB_W = 16;

  typedef enum logic {
    SEL_PSC = 1'b0,
    SEL_RLD = 1'b1
  } wr_sel_e;
endpackage

// File: rtl/tbase_shadow.sv
module tbase_shadow #(
  parameter int W = tbase_pkg::TB_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic         wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic         rld_defer,
  input  logic         upd,
  output logic [W-1:0] psc_act,
  output logic [W-1:0] rld_act
);
  logic [W-1:0] psc_sh;
  logic [W-1:0] rld_sh;
  logic         psc_wr;
  logic         rld_wr;
  logic         rld_direct;

  assign psc_wr     = wr_en && (wr_sel == tbase_pkg::SEL_PSC);
  assign rld_wr     = wr_en && (wr_sel == tbase_pkg::SEL_RLD);
  assign rld_direct = rld_wr && !rld_defer;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      psc_sh  <= '0;
      rld_sh  <= '0;
      psc_act <= '0;
      rld_act <= '0;
    end else begin
      if (psc_wr) psc_sh <= wr_data;
      if (rld_wr) rld_sh <= wr_data;
      if (upd) psc_act <= psc_sh;
      if (rld_direct) rld_act <= wr_data;
      else if (upd) rld_act <= rld_sh;
    end
  end
endmodule

// File: rtl/tbase_presc.sv
module tbase_presc #(
  parameter int W = tbase_pkg::TB_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         active,
  input  logic         upd,
  input  logic [W-1:0] psc_act,
  output logic         tick,
  output logic [W-1:0] pcnt
);
  function automatic logic [W-1:0] step_pos(input logic [W-1:0] pos, input logic last);
    return last ? '0 : pos + 1'b1;
  endfunction

  assign tick = active && (pcnt == psc_act);

  always_ff @(posedge clk) begin
    if (!rst_n)      pcnt <= '0;
    else if (upd)    pcnt <= '0;
    else if (active) pcnt <= step_pos(pcnt, tick);
  end
endmodule

// File: rtl/tbase_count.sv
module tbase_count #(
  parameter int W = tbase_pkg::TB_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         upd,
  input  logic [W-1:0] rld_act,
  output logic [W-1:0] cnt,
  output logic         at_limit
);
  function automatic logic hit_limit(input logic [W-1:0] c, input logic [W-1:0] lim);
    return c == lim;
  endfunction

  assign at_limit = hit_limit(cnt, rld_act);

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (upd)  cnt <= '0;
    else if (tick) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/tbase_core.sv
module tbase_core #(
  parameter int W = tbase_pkg::TB_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run_en,
  input  logic         rld_defer,
  input  logic         sw_update,
  input  logic         wr_en,
  input  logic         wr_sel,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] cnt_out,
  output logic         update_pulse,
  output logic         cnt_tick
);
  logic [W-1:0] psc_act;
  logic [W-1:0] rld_act;
  logic [W-1:0] pcnt;
  logic [W-1:0] cnt_q;
  logic         tick;
  logic         at_limit;
  logic         count_ok;
  logic         ovf_evt;
  logic         upd;

  assign count_ok = run_en && (rld_act != '0);
  assign ovf_evt  = tick && at_limit;
  assign upd      = sw_update || ovf_evt;

  tbase_shadow #(.W(W)) u_shadow (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rld_defer(rld_defer), .upd(upd),
    .psc_act(psc_act), .rld_act(rld_act)
  );

  tbase_presc #(.W(W)) u_presc (
    .clk(clk), .rst_n(rst_n), .active(count_ok), .upd(upd),
    .psc_act(psc_act), .tick(tick), .pcnt(pcnt)
  );

  tbase_count #(.W(W)) u_count (
    .clk(clk), .rst_n(rst_n), .tick(tick), .upd(upd),
    .rld_act(rld_act), .cnt(cnt_q), .at_limit(at_limit)
  );

  assign cnt_out      = cnt_q;
  assign update_pulse = upd;
  assign cnt_tick     = tick;
endmodule

// File: rtl/tbase_chk.sv
module tbase_chk #(
  parameter int W = tbase_pkg::TB_W
) (
  input logic         clk,
  input logic         rst_n,
  input logic         run_en,
  input logic         sw_update,
  input logic [W-1:0] cnt,
  input logic [W-1:0] pcnt,
  input logic [W-1:0] psc_act,
  input logic [W-1:0] rld_act,
  input logic         tick,
  input logic         upd
);
  // R4: a zero limit freezes the counter
  a_r4_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (rld_act == '0 && !sw_update) |=> $stable(cnt));

  // R10: run_en low holds the counter and the prescaler position
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !sw_update) |=> ($stable(cnt) && $stable(pcnt)));

  // R3: a tick that is not an update steps the counter by one
  a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !upd) |=> (cnt == $past(cnt) + 1'b1));

  // R6: every update leaves the counter at zero
  a_r6_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> (cnt == '0));

  // R9: every update restarts the prescaler
  a_r9_restart: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> (pcnt == '0));

  // R2: the active prescaler changes only on an update
  a_r2_psc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(psc_act));

  // R1: the prescaler position never passes the active ratio
  a_r1_bound: assert property (@(posedge clk) disable iff (!rst_n)
    pcnt <= psc_act);
endmodule

bind tbase_core tbase_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .run_en(run_en), .sw_update(sw_update),
  .cnt(cnt_q), .pcnt(pcnt), .psc_act(psc_act), .rld_act(rld_act),
  .tick(tick), .upd(upd)
);

// File: tb/tbase_core_tb_top.sv
`timescale 1ns/1ps
module tbase_core_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run_en = 1'b0;
  logic        rld_defer = 1'b0;
  logic        sw_update = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_sel = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] cnt_out;
  logic        update_pulse;
  logic        cnt_tick;

  int checks = 0;
  int errors = 0;
  // bench view: cycles counted since last update, active and pending settings
  int k = 0, P = 0, A = 0, Ps = 0, As = 0;

  always #10 clk = ~clk;

  tbase_core dut_i (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .rld_defer(rld_defer),
    .sw_update(sw_update), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .cnt_out(cnt_out), .update_pulse(update_pulse), .cnt_tick(cnt_tick)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic cyc(input string tag, input bit swu, input bit en,
                     input bit wr, input bit sel, input int data);
    bit act, etick, eupd;
    int ec, ep;
    @(negedge clk);
    sw_update = swu; run_en = en; wr_en = wr; wr_sel = sel; wr_data = data[15:0];
    #1;
    act   = en && (A != 0);
    ep    = k % (P + 1);
    ec    = k / (P + 1);
    etick = act && (ep == P);
    eupd  = swu || (etick && ec == A);
    check(tag, "cnt_out", int'(cnt_out), ec);
    check("R1", "cnt_tick", int'(cnt_tick), int'(etick));
    check("R6", "update_pulse", int'(update_pulse), int'(eupd));
    @(posedge clk);
    if (eupd) begin
      k = 0;
      P = Ps;
      A = (wr && sel && !rld_defer) ? data : As;
    end else begin
      if (act) k++;
      if (wr && sel && !rld_defer) A = data;
    end
    if (wr && !sel) Ps = data;
    if (wr && sel) As = data;
  endtask

  task automatic run(input string tag, input int n);
    for (int i = 0; i < n; i++) cyc(tag, 1'b0, 1'b1, 1'b0, 1'b0, 0);
  endtask

  task automatic setup(input int p, input int a);
    rld_defer = 1'b0;
    cyc("R2", 1'b0, 1'b0, 1'b1, 1'b0, p);
    cyc("R7", 1'b0, 1'b0, 1'b1, 1'b1, a);
    cyc("R8", 1'b1, 1'b0, 1'b0, 1'b0, 0);
  endtask

  initial begin
    #200000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R5: reset values
    check("R5", "cnt_out", int'(cnt_out), 0);
    check("R5", "cnt_tick", int'(cnt_tick), 0);
    check("R5", "update_pulse", int'(update_pulse), 0);
    // R4: zero limit after reset, counting allowed
    run("R4", 8);

    // R3 / R1 / R9: sweep ratio and limit over two full periods
    for (int p = 0; p < 4; p++) begin
      for (int a = 1; a < 5; a++) begin
        setup(p, a);
        run("R3", 2 * (p + 1) * (a + 1) + 2);
      end
    end

    // R2: prescaler write mid-period waits for the update
    setup(0, 3);
    run("R2", 2);
    cyc("R2", 1'b0, 1'b1, 1'b1, 1'b0, 2);
    run("R2", 20);

    // R8 / R9: forced update in the middle of a count
    run("R9", 4);
    cyc("R8", 1'b1, 1'b1, 1'b0, 1'b0, 0);
    run("R9", 10);

    // R7: deferred limit write
    setup(1, 3);
    rld_defer = 1'b1;
    run("R7", 3);
    cyc("R7", 1'b0, 1'b1, 1'b1, 1'b1, 6);
    run("R7", 30);

    // R7: immediate limit write
    rld_defer = 1'b0;
    setup(0, 2);
    cyc("R7", 1'b0, 1'b1, 1'b1, 1'b1, 5);
    run("R7", 16);

    // R10: paused counting holds
    run("R10", 3);
    for (int i = 0; i < 6; i++) cyc("R10", 1'b0, 1'b0, 1'b0, 1'b0, 0);
    run("R10", 8);

    // R4: limit forced to zero while running
    run("R4", 1);
    cyc("R4", 1'b0, 1'b1, 1'b1, 1'b1, 0);
    run("R4", 8);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule